// File: doc/BRIEF.md
# Lockable System Options and Debug Reset Block

This block sits on an 8-bit peripheral bus and holds two system-level registers. The options register carries the settings that govern the watchdog, stop mode and two pin functions. Software gets a single write to it after each reset. That first write takes effect, and from then on the register is sealed: every later write is dropped until the next reset. The seal is set by any write strobe to the options address. It does not matter whether the data differs from the current contents or whether the access comes from user code or from the debug host. Bits 3 and 2 are not implemented.

The second register is a force-reset register. Only an access marked by the debug sideband flag can act on it. A debug write with data bit 0 set produces a registered reset request that lasts one cycle. The system applies that request back to this block as `rst_n`. The force-reset register always reads as zero, and so does every unmapped address. Reads are combinational from the current address.

Two state machines carry the behaviour:
- Lock machine, states `LK_OPEN` and `LK_SEALED`.
  - Transition "seal": `LK_OPEN` to `LK_SEALED` on any options write. The written data is captured on the same edge.
  - Transition "hold": `LK_SEALED` stays in `LK_SEALED` until reset.
- Force machine, states `FR_IDLE` and `FR_FIRE`.
  - Transition "arm": `FR_IDLE` to `FR_FIRE` on a debug write to the force-reset address with bit 0 = 1.
  - Transition "retire": `FR_FIRE` always returns to `FR_IDLE` after one cycle. A force write that arrives during `FR_FIRE` is dropped.

Top module: `sys_cfg_regs`

## Requirements
- R1: After reset the options register reads 0xC2. The bit layout is: bit7 watchdog enable = 1, bit6 long timeout = 1, bit5 stop enable = 0, bit4 spare = 0, bit1 debug pin enable = 1, bit0 reset pin enable = 0. The option outputs match these values, and `sys_rst_req` is 0.
- R2: A read of the options address (default 0x01) returns the current options value in the same cycle, whether or not the register has been written.
- R3: The first write to the options address after reset stores the write data masked with 0xF3. The write may come from user code or from the debug host. The new value is visible from the clock edge that performs the write.
- R4: Every later write to the options address, from any source, leaves the register unchanged until the next reset.
- R5: A first write whose data equals the reset value still seals the register.
- R6: Bits 3 and 2 of the options register always read 0, and writing 1s to them has no effect.
- R7: A write to the force-reset address (default 0x00) with `bus_dbg` = 0 never raises `sys_rst_req`.
- R8: A debug write to the force-reset address with data bit 0 = 1 raises `sys_rst_req` for exactly one cycle, starting at the edge that performs the write. A debug write with bit 0 = 0 raises nothing. A force write made while the pulse is high is dropped.
- R9: Reads of the force-reset address always return 0x00.
- R10: Reads of any unmapped address return 0x00. Writes to unmapped addresses change no options and raise no reset request.
- R11: Applying reset again restores the reset value and reopens the options register for one more write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_dbg | input | 1 | Marks the access as coming from the debug host |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| opt_wdog_en | output | 1 | Watchdog enable option |
| opt_wdog_long | output | 1 | Watchdog long-timeout select |
| opt_stop_en | output | 1 | Stop mode enable |
| opt_spare | output | 1 | Spare option bit 4 |
| opt_dbgpin_en | output | 1 | Debug pin enable |
| opt_rstpin_en | output | 1 | Reset pin enable |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The checker assumes the following about the inputs:
- Bus inputs are free of unknowns and stay stable across each rising edge.
- Each write strobe lasts one cycle per intended write.
- `rst_n` is the only path that clears the seal.

Within those limits, the checker tracks its own record of whether an options write has been seen. It also assumes the reset request is never fed back within the same cycle.

The stimulus respects all of this:
- Every bus input changes only on falling edges, and writes are held for a single cycle.
- The bench applies reset itself after a pulse, instead of looping `sys_rst_req` into `rst_n`.
- Accesses are confined to the two mapped addresses and one unmapped address.

// File: rtl/sys_cfg_pkg.sv
package sys_cfg_pkg;

    localparam int DATA_W = 8;

    // value of the options register straight out of reset
    localparam logic [DATA_W-1:0] OPT_RESET     = 8'hC2;
    // bits 3 and 2 do not exist
    localparam logic [DATA_W-1:0] OPT_IMPL_MASK = 8'hF3;
    // force-reset trigger bit position
    localparam int FRC_TRIG_BIT = 0;

    typedef enum logic {
        LK_OPEN,
        LK_SEALED
    } lock_state_e;

    typedef enum logic {
        FR_IDLE,
        FR_FIRE
    } frc_state_e;

    typedef struct packed {
        logic       wdog_en;
        logic       wdog_long;
        logic       stop_en;
        logic       spare;
        logic [1:0] rsvd;
        logic       dbgpin_en;
        logic       rstpin_en;
    } opt_bits_t;

endpackage

// File: rtl/sys_cfg_decode.sv
module sys_cfg_decode #(
    parameter int                  ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]   OPT_ADDR = 'h01,
    parameter logic [ADDR_W-1:0]   FRC_ADDR = 'h00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              dbg,
    output logic              hit_opt,
    output logic              hit_frc,
    output logic              wr_opt,
    output logic              wr_frc_dbg
);
    always_comb begin
        hit_opt    = (addr == OPT_ADDR);
        hit_frc    = (addr == FRC_ADDR);
        // the options write is honoured from either source
        wr_opt     = wr && hit_opt;
        // the force register listens to the debug path only
        wr_frc_dbg = wr && dbg && hit_frc;
    end
endmodule

// File: rtl/sys_cfg_opt_lock.sv
module sys_cfg_opt_lock
    import sys_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_opt,
    input  logic [DATA_W-1:0] wdata,
    output opt_bits_t         opt_q
);
    lock_state_e state_q, state_nx;
    opt_bits_t   val_q, val_nx;

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            LK_OPEN:   if (wr_opt) state_nx = LK_SEALED;  // seal
            LK_SEALED: state_nx = LK_SEALED;              // hold
            default:   state_nx = LK_SEALED;
        endcase
    end

    // data captured only on the sealing write
    always_comb begin
        val_nx = val_q;
        unique case (state_q)
            LK_OPEN:   if (wr_opt) val_nx = opt_bits_t'(wdata & OPT_IMPL_MASK);
            LK_SEALED: val_nx = val_q;
            default:   val_nx = val_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= opt_bits_t'(OPT_RESET);
        else        val_q <= val_nx;
    end

    assign opt_q = val_q;
endmodule

// File: rtl/sys_cfg_frc.sv
module sys_cfg_frc
    import sys_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_frc_dbg,
    input  logic [DATA_W-1:0] wdata,
    output logic              rst_req
);
    frc_state_e state_q, state_nx;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            FR_IDLE: if (wr_frc_dbg && wdata[FRC_TRIG_BIT]) state_nx = FR_FIRE;  // arm
            FR_FIRE: state_nx = FR_IDLE;                                          // retire
            default: state_nx = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_nx;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            FR_FIRE: rst_req = 1'b1;
            default: rst_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/sys_cfg_rdmux.sv
module sys_cfg_rdmux
    import sys_cfg_pkg::*;
(
    input  logic              hit_opt,
    input  opt_bits_t         opt_q,
    output logic [DATA_W-1:0] rdata
);
    // force register and unmapped space both read as zero
    always_comb begin
        rdata = '0;
        if (hit_opt) rdata = opt_q & OPT_IMPL_MASK;
    end
endmodule

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs
    import sys_cfg_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OPT_ADDR = 'h01,
    parameter logic [ADDR_W-1:0] FRC_ADDR = 'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_dbg,
    output logic [7:0]        bus_rdata,
    output logic              opt_wdog_en,
    output logic              opt_wdog_long,
    output logic              opt_stop_en,
    output logic              opt_spare,
    output logic              opt_dbgpin_en,
    output logic              opt_rstpin_en,
    output logic              sys_rst_req
);
    logic      hit_opt, hit_frc, wr_opt, wr_frc_dbg;
    opt_bits_t opt_q;

    sys_cfg_decode #(
        .ADDR_W  (ADDR_W),
        .OPT_ADDR(OPT_ADDR),
        .FRC_ADDR(FRC_ADDR)
    ) u_decode (
        .addr      (bus_addr),
        .wr        (bus_wr),
        .dbg       (bus_dbg),
        .hit_opt   (hit_opt),
        .hit_frc   (hit_frc),
        .wr_opt    (wr_opt),
        .wr_frc_dbg(wr_frc_dbg)
    );

    sys_cfg_opt_lock u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_opt(wr_opt),
        .wdata (bus_wdata),
        .opt_q (opt_q)
    );

    sys_cfg_frc u_frc (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_frc_dbg(wr_frc_dbg),
        .wdata     (bus_wdata),
        .rst_req   (sys_rst_req)
    );

    sys_cfg_rdmux u_rdmux (
        .hit_opt(hit_opt),
        .opt_q  (opt_q),
        .rdata  (bus_rdata)
    );

    // hit_frc only selects zero read data; kept for decode symmetry
    logic unused_hit_frc;
    assign unused_hit_frc = hit_frc;

    assign opt_wdog_en   = opt_q.wdog_en;
    assign opt_wdog_long = opt_q.wdog_long;
    assign opt_stop_en   = opt_q.stop_en;
    assign opt_spare     = opt_q.spare;
    assign opt_dbgpin_en = opt_q.dbgpin_en;
    assign opt_rstpin_en = opt_q.rstpin_en;
endmodule

// File: rtl/sys_cfg_regs_chk.sv
module sys_cfg_regs_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OPT_ADDR = 'h01,
    parameter logic [ADDR_W-1:0] FRC_ADDR = 'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_wr,
    input logic              bus_dbg,
    input logic [7:0]        bus_rdata,
    input logic              opt_wdog_en,
    input logic              opt_wdog_long,
    input logic              opt_stop_en,
    input logic              opt_spare,
    input logic              opt_dbgpin_en,
    input logic              opt_rstpin_en,
    input logic              sys_rst_req
);
    logic [7:0] opt_vec;
    logic       seen_q;
    logic       trig;

    assign opt_vec = {opt_wdog_en, opt_wdog_long, opt_stop_en, opt_spare,
                      2'b00, opt_dbgpin_en, opt_rstpin_en};
    assign trig    = bus_wr && bus_dbg && (bus_addr == FRC_ADDR) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              seen_q <= 1'b0;
        else if (bus_wr && bus_addr == OPT_ADDR) seen_q <= 1'b1;
    end

    // R1
    reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> opt_vec == 8'hC2);

    // R4
    sealed_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |=> $stable(opt_vec));

    // R6
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OPT_ADDR) |-> bus_rdata[3:2] == 2'b00);

    // R9
    frc_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == FRC_ADDR) |-> bus_rdata == 8'h00);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != FRC_ADDR && bus_addr != OPT_ADDR) |-> bus_rdata == 8'h00);

    // R8
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !sys_rst_req) |=> sys_rst_req);

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    // R7
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(trig));
endmodule

bind sys_cfg_regs sys_cfg_regs_chk #(
    .ADDR_W  (ADDR_W),
    .OPT_ADDR(OPT_ADDR),
    .FRC_ADDR(FRC_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_dbg      (bus_dbg),
    .bus_rdata    (bus_rdata),
    .opt_wdog_en  (opt_wdog_en),
    .opt_wdog_long(opt_wdog_long),
    .opt_stop_en  (opt_stop_en),
    .opt_spare    (opt_spare),
    .opt_dbgpin_en(opt_dbgpin_en),
    .opt_rstpin_en(opt_rstpin_en),
    .sys_rst_req  (sys_rst_req)
);

// File: tb/sys_cfg_regs_test.sv
module sys_cfg_regs_test;
    localparam logic [7:0] A_OPT = 8'h01;
    localparam logic [7:0] A_FRC = 8'h00;
    localparam logic [7:0] A_GAP = 8'h05;

    typedef struct {
        string      req;
        logic [7:0] rd;
        logic [7:0] opt;
        logic       pulse;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_dbg = 1'b0;
    logic [7:0] bus_rdata;
    logic       opt_wdog_en, opt_wdog_long, opt_stop_en, opt_spare;
    logic       opt_dbgpin_en, opt_rstpin_en, sys_rst_req;

    exp_t       sb[$];
    int         checks = 0;
    int         fails = 0;
    logic [7:0] m_opt = 8'hC2;
    logic       m_sealed = 1'b0;
    logic       m_pulse = 1'b0;
    bit         done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    sys_cfg_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_dbg(bus_dbg), .bus_rdata(bus_rdata),
        .opt_wdog_en(opt_wdog_en), .opt_wdog_long(opt_wdog_long),
        .opt_stop_en(opt_stop_en), .opt_spare(opt_spare),
        .opt_dbgpin_en(opt_dbgpin_en), .opt_rstpin_en(opt_rstpin_en),
        .sys_rst_req(sys_rst_req)
    );

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // driver: one bus cycle, expectation from the bench's own model
    task automatic bus_op(logic [7:0] a, logic [7:0] d, logic w, logic g, string req);
        exp_t e;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = w; bus_dbg = g;
        if (w && a == A_OPT && !m_sealed) m_opt = d & 8'hF3;
        if (w && a == A_OPT) m_sealed = 1'b1;
        m_pulse = w && g && a == A_FRC && d[0] && !m_pulse;
        e.req = req;
        e.rd = (a == A_OPT) ? m_opt : 8'h00;
        e.opt = m_opt;
        e.pulse = m_pulse;
        sb.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; bus_dbg = 1'b0; bus_addr = A_GAP;
        m_opt = 8'hC2; m_sealed = 1'b0; m_pulse = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, "rdata", bus_rdata, e.rd);
                check(e.req, "options",
                      {opt_wdog_en, opt_wdog_long, opt_stop_en, opt_spare, 2'b00,
                       opt_dbgpin_en, opt_rstpin_en}, e.opt);
                check(e.req, "rst_req", {7'd0, sys_rst_req}, {7'd0, e.pulse});
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        bus_op(A_OPT, 8'h00, 0, 0, "R1");
        bus_op(A_OPT, 8'h00, 0, 1, "R2");
        bus_op(A_FRC, 8'h00, 0, 0, "R9");
        bus_op(A_GAP, 8'h00, 0, 0, "R10");
        bus_op(A_FRC, 8'h01, 1, 0, "R7");
        bus_op(A_FRC, 8'hFF, 1, 0, "R7");
        bus_op(A_FRC, 8'hFE, 1, 1, "R8");
        bus_op(A_FRC, 8'hFF, 1, 1, "R8");
        bus_op(A_FRC, 8'h01, 1, 1, "R8");
        bus_op(A_FRC, 8'h00, 0, 1, "R9");
        bus_op(A_GAP, 8'hFF, 1, 1, "R10");
        bus_op(A_GAP, 8'h3C, 1, 0, "R10");
        bus_op(A_OPT, 8'h00, 0, 0, "R2");
        bus_op(A_OPT, 8'h3F, 1, 0, "R3");
        bus_op(A_OPT, 8'h00, 0, 0, "R6");
        bus_op(A_OPT, 8'hFF, 1, 0, "R4");
        bus_op(A_OPT, 8'h00, 1, 1, "R4");
        bus_op(A_OPT, 8'h00, 0, 0, "R4");
        do_reset();
        bus_op(A_OPT, 8'h00, 0, 0, "R11");
        bus_op(A_OPT, 8'hC2, 1, 0, "R5");
        bus_op(A_OPT, 8'h00, 1, 0, "R5");
        bus_op(A_OPT, 8'h00, 0, 0, "R5");
        do_reset();
        bus_op(A_OPT, 8'h5D, 1, 1, "R3");
        bus_op(A_OPT, 8'h0C, 0, 0, "R6");
        bus_op(A_OPT, 8'hA2, 1, 1, "R4");
        bus_op(A_FRC, 8'h01, 1, 1, "R8");
        bus_op(A_OPT, 8'h00, 0, 0, "R2");
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule